// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects interrupt requests from a set of peripheral groups and delivers them to a host processor as a single request line. Requests are organised in two levels. Two groups, the card slots and the external I/O pins, own a bank of individual sub-source flags. Each flag is captured on a rising edge of its input, can be cleared by software, and rolls up into one summary bit. The other groups drive their summary bits directly as level signals. A global enable decides whether any summary bit reaches the host line.

Software reaches the block through a simple synchronous register bus. It has a select, a write strobe, a byte address, write data and combinational read data. A flag is captured only while its status-enable bit is set. It is forwarded into its summary bit only while its interrupt-enable bit is set. Flags are acknowledged by writing ones back to their status register. All peripheral inputs are synchronous to the block clock. The output line is registered by default, so the host, which detects edges, sees a clean transition whenever delivery resumes.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every enable register, every flag, the global enable and `irq_o` are 0, and every mapped register reads 0 while the peripheral inputs are low.
- R2: A sub-source flag is set only by a rising edge of its input, seen while its status-enable bit is 1. An input held high does not set the flag again after it is cleared.
- R3: Writing 1 to a bit of the card status register (offset 0x04, bits [3:0]) or the external status register (offset 0x08, bits [5:0]) clears that flag. Writing 0 leaves it unchanged. Writes to the top status register (offset 0x00) have no effect.
- R4: When a capturing edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Interrupt-enable bits only gate forwarding. A latched flag stays visible in its status register while its interrupt-enable bit is 0.
- R6: Top status bit 0 is the OR of the external flags ANDed with their interrupt enables. Bit 1 is the same for the card flags.
- R7: Top status bits 2 and 3 (slot-1 and slot-2 change) and bit 4 (display) follow their level inputs with no enable. They are read-only and cleared only by the peripheral.
- R8: USB enable (offset 0x14) bit 0 gates the USB request onto top bit 5, and bit 1 gates the USB wake request onto top bit 6. Management enable (offset 0x18) bit 0 gates the management request onto top bit 7.
- R9: `irq_o` equals the OR of the top status bits ANDed with global enable bit 0 (offset 0x1C), registered one cycle later. Global enable 0 holds `irq_o` low.
- R10: If enabled status is pending while the global enable is 0, setting the global enable gives a fresh 0-to-1 transition on `irq_o`.
- R11: Card enable (offset 0x0C) holds the interrupt enables in bits [3:0] and the status enables in bits [11:8]. External enable (offset 0x10) holds the interrupt enables in bits [5:0] and the status enables in bits [13:8]. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | ADDR_W | Byte address, word aligned |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address (combinational) |
| card_src_i | input | CARD_N | Card sub-source requests (slot-1 I/O, slot-1 ring, slot-2 I/O, slot-2 ring) |
| ext_src_i | input | EXT_N | External pin sub-source requests |
| slot1_chg_i | input | 1 | Slot-1 status change level |
| slot2_chg_i | input | 1 | Slot-2 status change level |
| disp_req_i | input | 1 | Display request level |
| usb_req_i | input | 1 | USB request level |
| usb_wake_i | input | 1 | USB wake request level |
| sysmgmt_req_i | input | 1 | System management request level |
| irq_o | output | 1 | Request line to the host |

## Verification
The timing of each result depends on the path it takes.
- A rising sub-source input present before clock edge k sets its flag at edge k. The status registers show the flag at the following falling edge.
- `irq_o` follows one edge later, at k+1.
- A register write taken at edge k is visible on reads right after k. Its effect on `irq_o` appears at edge k+1.

The bench drives inputs and samples outputs on falling edges only. Each task advances exactly the counted number of edges before every check. The latency checks also test the intermediate edge, where `irq_o` must not yet have moved.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

   // byte offsets of the register map (word aligned)
   localparam int unsigned OFS_TOP_ST   = 'h00;
   localparam int unsigned OFS_CARD_ST  = 'h04;
   localparam int unsigned OFS_EXT_ST   = 'h08;
   localparam int unsigned OFS_CARD_EN  = 'h0C;
   localparam int unsigned OFS_EXT_EN   = 'h10;
   localparam int unsigned OFS_USB_EN   = 'h14;
   localparam int unsigned OFS_MGMT_EN  = 'h18;
   localparam int unsigned OFS_GLOB_EN  = 'h1C;

   // top status bit positions
   typedef enum int unsigned {
      TOP_EXT   = 0,
      TOP_CARD  = 1,
      TOP_SLOT1 = 2,
      TOP_SLOT2 = 3,
      TOP_DISP  = 4,
      TOP_USB   = 5,
      TOP_WAKE  = 6,
      TOP_MGMT  = 7
   } top_bit_e;

   localparam int unsigned TOP_N = 8;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] sen_i,
   input  logic [N-1:0] ien_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o,
   output logic         fwd_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   logic [N-1:0] src_q;
   logic [N-1:0] flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q <= '0;
      else         src_q <= src_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic hit;
      assign hit = sen_i[i] & src_i[i] & ~src_q[i];

      // capture has priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        flag_q[i] <= 1'b0;
         else if (hit)       flag_q[i] <= 1'b1;
         else if (clr_i[i])  flag_q[i] <= 1'b0;
      end

      // R2
      flag_needs_sen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(flag_q[i]) |-> $past(sen_i[i]) && $past(src_i[i]));

      // R3
      flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[i] && !src_i[i]) |=> !flag_q[i]);
   end

   assign flag_o = flag_q;
   assign fwd_o  = |(flag_q & ien_i);

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
   import irq_tree_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CARD_N = 4,
   parameter int unsigned EXT_N  = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [TOP_N-1:0]  top_i,
   input  logic [CARD_N-1:0] card_flag_i,
   input  logic [EXT_N-1:0]  ext_flag_i,
   output logic [CARD_N-1:0] card_ien_o,
   output logic [CARD_N-1:0] card_sen_o,
   output logic [CARD_N-1:0] card_clr_o,
   output logic [EXT_N-1:0]  ext_ien_o,
   output logic [EXT_N-1:0]  ext_sen_o,
   output logic [EXT_N-1:0]  ext_clr_o,
   output logic [1:0]        usb_en_o,
   output logic              mgmt_en_o,
   output logic              glob_en_o
);

   localparam int unsigned HALF = DATA_W / 2;

   if (DATA_W < TOP_N) begin : g_bad_dw
      $error("irq_ctl_regs: DATA_W must hold the top status");
   end
   if (CARD_N > HALF || EXT_N > HALF) begin : g_bad_split
      $error("irq_ctl_regs: sub-source count exceeds half the data width");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("irq_ctl_regs: ADDR_W too small for the register map");
   end

   logic wr_en;
   assign wr_en = sel_i & wr_i;

   function automatic logic hit_at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [CARD_N-1:0] card_ien_q, card_sen_q;
   logic [EXT_N-1:0]  ext_ien_q,  ext_sen_q;
   logic [1:0]        usb_en_q;
   logic              mgmt_en_q, glob_en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         card_ien_q <= '0;
         card_sen_q <= '0;
         ext_ien_q  <= '0;
         ext_sen_q  <= '0;
         usb_en_q   <= '0;
         mgmt_en_q  <= 1'b0;
         glob_en_q  <= 1'b0;
      end else if (wr_en) begin
         if (hit_at(addr_i, OFS_CARD_EN)) begin
            card_ien_q <= wdata_i[CARD_N-1:0];
            card_sen_q <= wdata_i[HALF +: CARD_N];
         end
         if (hit_at(addr_i, OFS_EXT_EN)) begin
            ext_ien_q <= wdata_i[EXT_N-1:0];
            ext_sen_q <= wdata_i[HALF +: EXT_N];
         end
         if (hit_at(addr_i, OFS_USB_EN))  usb_en_q  <= wdata_i[1:0];
         if (hit_at(addr_i, OFS_MGMT_EN)) mgmt_en_q <= wdata_i[0];
         if (hit_at(addr_i, OFS_GLOB_EN)) glob_en_q <= wdata_i[0];
      end
   end

   // write-one-to-clear strobes toward the flag banks
   assign card_clr_o = (wr_en && hit_at(addr_i, OFS_CARD_ST)) ? wdata_i[CARD_N-1:0] : '0;
   assign ext_clr_o  = (wr_en && hit_at(addr_i, OFS_EXT_ST))  ? wdata_i[EXT_N-1:0]  : '0;

   always_comb begin
      rdata_o = '0;
      if (hit_at(addr_i, OFS_TOP_ST))  rdata_o[TOP_N-1:0]  = top_i;
      if (hit_at(addr_i, OFS_CARD_ST)) rdata_o[CARD_N-1:0] = card_flag_i;
      if (hit_at(addr_i, OFS_EXT_ST))  rdata_o[EXT_N-1:0]  = ext_flag_i;
      if (hit_at(addr_i, OFS_CARD_EN)) begin
         rdata_o[CARD_N-1:0]    = card_ien_q;
         rdata_o[HALF +: CARD_N] = card_sen_q;
      end
      if (hit_at(addr_i, OFS_EXT_EN)) begin
         rdata_o[EXT_N-1:0]    = ext_ien_q;
         rdata_o[HALF +: EXT_N] = ext_sen_q;
      end
      if (hit_at(addr_i, OFS_USB_EN))  rdata_o[1:0] = usb_en_q;
      if (hit_at(addr_i, OFS_MGMT_EN)) rdata_o[0]   = mgmt_en_q;
      if (hit_at(addr_i, OFS_GLOB_EN)) rdata_o[0]   = glob_en_q;
   end

   // R1
   glob_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(glob_en_q) |-> $past(wr_en) && $past(wdata_i[0]));

   assign card_ien_o = card_ien_q;
   assign card_sen_o = card_sen_q;
   assign ext_ien_o  = ext_ien_q;
   assign ext_sen_o  = ext_sen_q;
   assign usb_en_o   = usb_en_q;
   assign mgmt_en_o  = mgmt_en_q;
   assign glob_en_o  = glob_en_q;

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
   parameter int unsigned TOP_W    = 8,
   parameter bit          SYNC_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [TOP_W-1:0] top_i,
   input  logic             glob_en_i,
   output logic             irq_o
);

   logic req;
   assign req = glob_en_i & (|top_i);

   if (SYNC_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= req;
      end
      assign irq_o = irq_q;

      // R9
      glob_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !glob_en_i |=> !irq_o);

      // R9
      irq_has_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> $past(|top_i));

      // R10
      fresh_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($rose(glob_en_i) && (|top_i)) |=> $rose(irq_o));
   end else begin : g_comb
      assign irq_o = req;
   end

endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
   import irq_tree_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned CARD_N   = 4,
   parameter int unsigned EXT_N    = 6,
   parameter bit          SYNC_OUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic [CARD_N-1:0] card_src_i,
   input  logic [EXT_N-1:0]  ext_src_i,
   input  logic              slot1_chg_i,
   input  logic              slot2_chg_i,
   input  logic              disp_req_i,
   input  logic              usb_req_i,
   input  logic              usb_wake_i,
   input  logic              sysmgmt_req_i,
   output logic              irq_o
);

   logic [CARD_N-1:0] card_ien, card_sen, card_clr, card_flag;
   logic [EXT_N-1:0]  ext_ien, ext_sen, ext_clr, ext_flag;
   logic [1:0]        usb_en;
   logic              mgmt_en, glob_en;
   logic              card_fwd, ext_fwd;
   logic [TOP_N-1:0]  top_st;

   irq_flag_bank #(.N(CARD_N)) u_card (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .src_i (card_src_i), .sen_i(card_sen), .ien_i(card_ien), .clr_i(card_clr),
      .flag_o(card_flag), .fwd_o(card_fwd)
   );

   irq_flag_bank #(.N(EXT_N)) u_ext (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .src_i (ext_src_i), .sen_i(ext_sen), .ien_i(ext_ien), .clr_i(ext_clr),
      .flag_o(ext_flag), .fwd_o(ext_fwd)
   );

   always_comb begin
      top_st            = '0;
      top_st[TOP_EXT]   = ext_fwd;
      top_st[TOP_CARD]  = card_fwd;
      top_st[TOP_SLOT1] = slot1_chg_i;
      top_st[TOP_SLOT2] = slot2_chg_i;
      top_st[TOP_DISP]  = disp_req_i;
      top_st[TOP_USB]   = usb_req_i  & usb_en[0];
      top_st[TOP_WAKE]  = usb_wake_i & usb_en[1];
      top_st[TOP_MGMT]  = sysmgmt_req_i & mgmt_en;
   end

   irq_ctl_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CARD_N(CARD_N), .EXT_N(EXT_N)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (bus_sel_i),
      .wr_i       (bus_wr_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .rdata_o    (bus_rdata_o),
      .top_i      (top_st),
      .card_flag_i(card_flag),
      .ext_flag_i (ext_flag),
      .card_ien_o (card_ien),
      .card_sen_o (card_sen),
      .card_clr_o (card_clr),
      .ext_ien_o  (ext_ien),
      .ext_sen_o  (ext_sen),
      .ext_clr_o  (ext_clr),
      .usb_en_o   (usb_en),
      .mgmt_en_o  (mgmt_en),
      .glob_en_o  (glob_en)
   );

   irq_out_stage #(.TOP_W(TOP_N), .SYNC_OUT(SYNC_OUT)) u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .top_i    (top_st),
      .glob_en_i(glob_en),
      .irq_o    (irq_o)
   );

   // R8
   usb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!usb_req_i && !usb_wake_i && !sysmgmt_req_i) |-> (top_st[7:5] == 3'b000));

endmodule

// File: tb/irq_tree_ctrl_test.sv
module irq_tree_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [3:0]    card_src = '0;
   logic [5:0]    ext_src = '0;
   logic          s1 = 0, s2 = 0, disp = 0, usb = 0, wake = 0, sm = 0;
   logic          irq;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_tree_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .card_src_i(card_src), .ext_src_i(ext_src),
      .slot1_chg_i(s1), .slot2_chg_i(s2), .disp_req_i(disp),
      .usb_req_i(usb), .usb_wake_i(wake), .sysmgmt_req_i(sm),
      .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input int a, input logic [DW-1:0] d);
      sel = 1; wr = 1; addr = AW'(a); wdata = d;
      tick();
      sel = 0; wr = 0; wdata = '0;
   endtask

   task automatic rd_reg(input int a, output logic [DW-1:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      for (int a = 0; a < 'h20; a += 4) begin
         rd_reg(a, d);
         chk("R1 register zero after reset", d, 0);
      end
      chk("R1 irq low after reset", irq, 0);
      rd_reg('h24, d);
      chk("R11 unmapped offset reads zero", d, 0);
   endtask

   task automatic t_latch_gate();
      logic [DW-1:0] d;
      card_src[0] = 1; tick(); card_src[0] = 0; tick();
      rd_reg('h04, d);
      chk("R2 no capture with status enable off", d, 0);
      wr_reg('h0C, 16'h0F00);
      rd_reg('h0C, d);
      chk("R11 card enable field layout", d, 16'h0F00);
      card_src[0] = 1; tick();
      rd_reg('h04, d);
      chk("R2 capture on rising edge", d, 16'h0001);
      wr_reg('h04, 16'h0001);
      tick(); tick();
      rd_reg('h04, d);
      chk("R2 held level does not recapture", d, 0);
      card_src[0] = 0; tick();
   endtask

   task automatic t_w1c();
      logic [DW-1:0] d;
      card_src = 4'b0101; tick(); card_src = 0; tick();
      rd_reg('h04, d);
      chk("R3 two flags latched", d, 16'h0005);
      wr_reg('h04, 16'h0004);
      rd_reg('h04, d);
      chk("R3 write one clears only that bit", d, 16'h0001);
      wr_reg('h04, 16'h0000);
      rd_reg('h04, d);
      chk("R3 write zero leaves flags", d, 16'h0001);
      wr_reg('h00, 16'hFFFF);
      rd_reg('h04, d);
      chk("R3 top status write has no effect", d, 16'h0001);
      wr_reg('h04, 16'h000F);
      rd_reg('h04, d);
      chk("R3 all flags cleared", d, 0);
   endtask

   task automatic t_race();
      logic [DW-1:0] d;
      wr_reg('h10, 16'h2800);
      rd_reg('h10, d);
      chk("R11 external enable field layout", d, 16'h2800);
      ext_src = 6'b101000; tick(); ext_src = 0; tick();
      rd_reg('h08, d);
      chk("R4 precondition flags", d, 16'h0028);
      ext_src[3] = 1;
      sel = 1; wr = 1; addr = AW'('h08); wdata = 16'h0028;
      tick();
      sel = 0; wr = 0; wdata = '0;
      ext_src[3] = 0;
      rd_reg('h08, d);
      chk("R4 capture beats clear", d, 16'h0008);
   endtask

   task automatic t_mask();
      logic [DW-1:0] d;
      rd_reg('h00, d);
      chk("R5 masked flag not forwarded", d, 0);
      rd_reg('h08, d);
      chk("R5 masked flag still visible", d, 16'h0008);
      wr_reg('h10, 16'h2808);
      rd_reg('h00, d);
      chk("R6 external summary bit 0", d, 16'h0001);
      card_src[3] = 1; tick(); card_src[3] = 0;
      rd_reg('h00, d);
      chk("R6 card flag without interrupt enable", d, 16'h0001);
      wr_reg('h0C, 16'h0F08);
      rd_reg('h00, d);
      chk("R6 card summary bit 1", d, 16'h0003);
      wr_reg('h04, 16'h000F);
      rd_reg('h00, d);
      chk("R6 card summary clears with flag", d, 16'h0001);
   endtask

   task automatic t_direct();
      logic [DW-1:0] d;
      wr_reg('h10, 16'h2800);
      s1 = 1; disp = 1; #1;
      rd_reg('h00, d);
      chk("R7 slot1 and display levels", d, 16'h0014);
      wr_reg('h00, 16'hFFFF);
      rd_reg('h00, d);
      chk("R7 direct bits not cleared by write", d, 16'h0014);
      s1 = 0; disp = 0; s2 = 1;
      rd_reg('h00, d);
      chk("R7 slot2 level", d, 16'h0008);
      s2 = 0;
      rd_reg('h00, d);
      chk("R7 direct bits cleared by peripheral", d, 0);
   endtask

   task automatic t_usb_mgmt();
      logic [DW-1:0] d;
      usb = 1; wake = 1; sm = 1;
      rd_reg('h00, d);
      chk("R8 all gated off", d, 0);
      wr_reg('h14, 16'h0001);
      rd_reg('h00, d);
      chk("R8 USB enable bit 0 gates bit 5", d, 16'h0020);
      wr_reg('h14, 16'h0002);
      rd_reg('h00, d);
      chk("R8 USB enable bit 1 gates bit 6", d, 16'h0040);
      wr_reg('h18, 16'h0001);
      rd_reg('h00, d);
      chk("R8 management enable gates bit 7", d, 16'h00C0);
      usb = 0; wake = 0; sm = 0;
      wr_reg('h14, 0); wr_reg('h18, 0);
   endtask

   task automatic t_output();
      ext_src[5] = 1; tick(); ext_src[5] = 0;
      wr_reg('h10, 16'h2820);
      tick();
      chk("R9 global enable off blocks irq", irq, 0);
      wr_reg('h1C, 1);
      chk("R9 irq not yet set one edge after enable", irq, 0);
      tick();
      chk("R9 irq set after second edge", irq, 1);
      wr_reg('h1C, 0);
      tick();
      chk("R9 irq low after disable", irq, 0);
      wr_reg('h1C, 1);
      chk("R10 irq still low before edge", irq, 0);
      tick();
      chk("R10 fresh rising edge after re-enable", irq, 1);
      wr_reg('h08, 16'h003F);
      tick();
      chk("R9 irq drops after clearing flags", irq, 0);
      ext_src[5] = 1; tick();
      chk("R9 flag set, irq pending register", irq, 0);
      tick();
      chk("R9 irq from new capture", irq, 1);
      ext_src[5] = 0;
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_latch_gate();
      t_w1c();
      t_race();
      t_mask();
      t_direct();
      t_usb_mgmt();
      t_output();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule